// File: doc/BRIEF.md
# Systolic Serial/Parallel Unsigned Multiplier

This block multiplies unsigned integers of `N` bits using a bit-serial systolic array. The multiplicand is taken in parallel at the start of each word. The multiplier streams in one bit per clock, least significant bit first, and a word-start strobe marks bit 0. The block returns the full `2N`-bit product on two serial lines. The low half leaves on `prod_lo` while the word is still arriving, with one clock of latency. The high half leaves on `prod_hi` during the `N` clocks after the word ends. Words may follow each other with no idle or padding words between them.

Each of the `N` stages holds a pair of adjacent cells. Each cell has an AND gate, a full adder, and registered sum and carry bits, and connects only to its nearest neighbour. The accumulate cell of a stage builds the current word's product in carry-save form. When a word completes, its sum and carry state moves sideways into the drain cell of the same stage. The drain cell then keeps adding with a zero partial product, which shifts out the high half. At the same time the accumulate chain restarts from zero for the next word. A squaring mode takes the multiplicand from the previous serial word, which a shift register captures, instead of from the parallel input. Squaring a value therefore means streaming it twice.

A small controller sequences the word. In state IDLE no word is open. The transition IDLE→RUN happens on a start strobe. The controller stays in RUN→RUN while bits 1..N-2 are taken, and moves RUN→DONE after bit N-1. In DONE the completed word is handed to the drain cells. From DONE it goes DONE→RUN if a new start strobe is present, or DONE→IDLE if none is.

Top module: `ssp_mult`

## Requirements
- R1: After reset, `prod_lo` and `prod_hi` are both 0 until the first word is started.
- R2: Bit k of the product (k = 0..N-1) is on `prod_lo` during the clock after the rising edge that samples bit k of the serial multiplier, which is one clock of latency.
- R3: Bit N+j of the product (j = 0..N-1) is on `prod_hi` during the clock after the rising edge that comes N+j edges after the edge that sampled the word's start. The full 2N-bit product is exact, including for all-ones operands.
- R4: A word whose start strobe arrives right after the previous word's bit N-1 is computed correctly. The outgoing high half of the previous word is not disturbed by it.
- R5: Between words (state IDLE), `prod_lo` is 0 and the serial input is ignored. Idle cycles do not disturb the high half still draining.
- R6: The parallel multiplicand is captured on the cycle the start strobe is accepted. Changes on `opa` during bits 1..N-1 have no effect on that word's product.
- R7: A start strobe raised while a word is in progress (bits 1..N-1) is ignored. The bit on `ser_b` in that cycle is taken as an ordinary data bit.
- R8: When `sq_mode` is 1 on the accepted start, the multiplicand is the previous word's serial value and `opa` is ignored. Streaming x twice, with `sq_mode` high on the second word, yields x·x.
- R9: The controller makes the transitions IDLE→RUN on start, RUN→DONE after bit N-1, DONE→RUN on start, and DONE→IDLE without start. A new word may begin either directly from DONE or after any number of idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| word_start | input | 1 | High on the cycle carrying bit 0 of a word |
| ser_b | input | 1 | Serial multiplier bit, LSB first |
| opa | input | N | Parallel multiplicand, captured on an accepted start |
| sq_mode | input | 1 | Squaring mode, sampled with an accepted start |
| prod_lo | output | 1 | Serial low half of the product, LSB first |
| prod_hi | output | 1 | Serial high half of the product, LSB first |

## Verification
The assertions take for granted that a word is sent as exactly N consecutive bits after its start strobe, with no gaps inside the word. Under that assumption the controller's position in the word matches the true bit index. The stimulus always drives N bits per word without pause. It only varies things the block must tolerate: the length of gaps between words (zero or more), noise on `opa` and `ser_b` when they are not sampled, and stray start pulses inside a word.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_RUN  = 2'd1,
        S_DONE = 2'd2
    } ssp_state_e;

endpackage

// File: rtl/ssp_cell.sv
// One multiplier cell: partial product, full adder, registered sum and carry.
module ssp_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic x,
    input  logic y,
    input  logic z,
    output logic s_q,
    output logic c_q
);
    logic s_d;
    logic c_d;

    always_comb begin
        s_d = x ^ y ^ z;
        c_d = (x & y) | (x & z) | (y & z);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= 1'b0;
            c_q <= 1'b0;
        end else begin
            s_q <= s_d;
            c_q <= c_d;
        end
    end
endmodule

// File: rtl/ssp_stage.sv
// One array position: an accumulate cell and a drain cell side by side.
module ssp_stage (
    input  logic clk,
    input  logic rst_n,
    input  logic a_bit,
    input  logic b_bit,
    input  logic clr_acc,
    input  logic xfer,
    input  logic acc_s_left,
    input  logic drn_s_left,
    output logic acc_s,
    output logic drn_s
);
    logic acc_c;
    logic drn_c;
    logic acc_y;
    logic acc_z;
    logic drn_y;
    logic drn_z;

    always_comb begin
        acc_y = clr_acc ? 1'b0 : acc_s_left;
        acc_z = clr_acc ? 1'b0 : acc_c;
        drn_y = xfer ? acc_s_left : drn_s_left;
        drn_z = xfer ? acc_c : drn_c;
    end

    ssp_cell u_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .x     (a_bit & b_bit),
        .y     (acc_y),
        .z     (acc_z),
        .s_q   (acc_s),
        .c_q   (acc_c)
    );

    ssp_cell u_drn (
        .clk   (clk),
        .rst_n (rst_n),
        .x     (1'b0),
        .y     (drn_y),
        .z     (drn_z),
        .s_q   (drn_s),
        .c_q   (drn_c)
    );
endmodule

// File: rtl/ssp_ctrl.sv
// Word sequencer: IDLE / RUN / DONE.
module ssp_ctrl
    import ssp_pkg::*;
#(
    parameter int N = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       word_start,
    output ssp_state_e state,
    output logic       accept,
    output logic       take
);
    localparam int CW = (N > 1) ? $clog2(N) : 1;
    localparam logic [CW-1:0] LAST = CW'(N - 1);

    ssp_state_e      state_n;
    logic [CW-1:0]   cnt;
    logic [CW-1:0]   cnt_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
        end
    end

    always_comb begin
        state_n = state;
        cnt_n   = cnt;
        unique case (state)
            S_IDLE, S_DONE: begin
                if (word_start) begin
                    state_n = S_RUN;
                    cnt_n   = CW'(1);
                end else begin
                    state_n = S_IDLE;
                    cnt_n   = '0;
                end
            end
            S_RUN: begin
                if (cnt == LAST) begin
                    state_n = S_DONE;
                    cnt_n   = '0;
                end else begin
                    cnt_n = cnt + CW'(1);
                end
            end
            default: begin
                state_n = S_IDLE;
                cnt_n   = '0;
            end
        endcase
    end

    always_comb begin
        accept = 1'b0;
        take   = 1'b0;
        unique case (state)
            S_IDLE, S_DONE: begin
                accept = word_start;
                take   = word_start;
            end
            S_RUN: begin
                take = 1'b1;
            end
            default: begin
                accept = 1'b0;
                take   = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/ssp_mult.sv
module ssp_mult
    import ssp_pkg::*;
#(
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         word_start,
    input  logic         ser_b,
    input  logic [N-1:0] opa,
    input  logic         sq_mode,
    output logic         prod_lo,
    output logic         prod_hi
);
    ssp_state_e   state;
    logic         accept;
    logic         take;
    logic         xfer;
    logic         clr_acc;
    logic         b_g;
    logic [N-1:0] a_reg;
    logic [N-1:0] a_eff;
    logic [N-1:0] cap;
    logic [N:0]   acc_s;
    logic [N:0]   drn_s;

    ssp_ctrl #(.N(N)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .word_start (word_start),
        .state      (state),
        .accept     (accept),
        .take       (take)
    );

    always_comb begin
        xfer    = (state == S_DONE);
        clr_acc = (state != S_RUN);
        b_g     = ser_b & take;
        if (accept) begin
            a_eff = sq_mode ? cap : opa;
        end else begin
            a_eff = a_reg;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_reg <= '0;
            cap   <= '0;
        end else begin
            if (accept) begin
                a_reg <= a_eff;
            end
            if (take) begin
                cap <= {ser_b, cap[N-1:1]};
            end
        end
    end

    assign acc_s[N] = 1'b0;
    assign drn_s[N] = 1'b0;

    for (genvar i = 0; i < N; i++) begin : g_stage
        ssp_stage u_stage (
            .clk        (clk),
            .rst_n      (rst_n),
            .a_bit      (a_eff[i]),
            .b_bit      (b_g),
            .clr_acc    (clr_acc),
            .xfer       (xfer),
            .acc_s_left (acc_s[i+1]),
            .drn_s_left (drn_s[i+1]),
            .acc_s      (acc_s[i]),
            .drn_s      (drn_s[i])
        );
    end

    assign prod_lo = acc_s[0];
    assign prod_hi = drn_s[0];
endmodule

// File: rtl/ssp_mult_chk.sv
module ssp_mult_chk
    import ssp_pkg::*;
#(
    parameter int N = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         word_start,
    input logic         prod_lo,
    input ssp_state_e   state,
    input logic [N-1:0] a_reg
);
    a_r9_idle_start: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && word_start) |=> (state == S_RUN));

    a_r9_done_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DONE && word_start) |=> (state == S_RUN));

    a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DONE && !word_start) |=> (state == S_IDLE));

    a_r5_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE) |-> !prod_lo);

    a_r6_operand_held: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_RUN && $past(state) == S_RUN) |-> $stable(a_reg));

    a_r7_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_RUN) |=> (state != S_IDLE));
endmodule

bind ssp_mult ssp_mult_chk #(.N(N)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .word_start (word_start),
    .prod_lo    (prod_lo),
    .state      (state),
    .a_reg      (a_reg)
);

// File: tb/tb_ssp_mult.sv
module tb_ssp_mult;
    localparam int N = 16;

    typedef struct {
        int unsigned     t;
        logic [2*N-1:0]  p;
        string           tag;
    } item_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         word_start = 1'b0;
    logic         ser_b = 1'b0;
    logic [N-1:0] opa = '0;
    logic         sq_mode = 1'b0;
    logic         prod_lo;
    logic         prod_hi;

    int unsigned  cyc = 0;
    int           checks = 0;
    int           errors = 0;
    int           pushed = 0;
    int           lo_done = 0;
    int           hi_done = 0;
    bit           finished = 1'b0;
    logic [N-1:0] last_b = '0;
    item_t        lo_q[$];
    item_t        hi_q[$];

    ssp_mult #(.N(N)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .word_start (word_start),
        .ser_b      (ser_b),
        .opa        (opa),
        .sq_mode    (sq_mode),
        .prod_lo    (prod_lo),
        .prod_hi    (prod_hi)
    );

    always #5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic send_word(input logic [N-1:0] a, input logic [N-1:0] b,
                             input bit sq, input int mid, input bit wiggle,
                             input string tag);
        item_t it;
        logic [N-1:0] mult;
        for (int k = 0; k < N; k++) begin
            @(negedge clk);
            word_start = (k == 0) || (k == mid);
            ser_b      = b[k];
            sq_mode    = (k == 0) ? sq : ~sq;
            opa        = (k == 0 || !wiggle) ? a : N'($urandom);
            if (k == 0) begin
                mult  = sq ? last_b : a;
                it.t  = cyc + 1;
                it.p  = (2*N)'(mult) * (2*N)'(b);
                it.tag = tag;
                lo_q.push_back(it);
                hi_q.push_back(it);
                pushed++;
                last_b = b;
            end
        end
    endtask

    task automatic idle(input int cycles);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (i == 1) begin
                checks++;
                if (prod_lo !== 1'b0) begin
                    errors++;
                    $display("FAIL R5 idle prod_lo actual %b expected 0", prod_lo);
                end
            end
            word_start = 1'b0;
            ser_b      = 1'($urandom);
            opa        = N'($urandom);
            sq_mode    = 1'($urandom);
        end
    endtask

    // low-half monitor (R2)
    initial begin
        item_t it;
        logic [N-1:0] got;
        forever begin
            wait (lo_q.size() > 0);
            it = lo_q.pop_front();
            for (int k = 0; k < N; k++) begin
                while (cyc < it.t + k) @(negedge clk);
                got[k] = prod_lo;
            end
            checks++;
            if (got !== it.p[N-1:0]) begin
                errors++;
                $display("FAIL R2 %s low half actual %h expected %h", it.tag, got, it.p[N-1:0]);
            end
            lo_done++;
        end
    end

    // high-half monitor (R3)
    initial begin
        item_t it;
        logic [N-1:0] got;
        forever begin
            wait (hi_q.size() > 0);
            it = hi_q.pop_front();
            for (int j = 0; j < N; j++) begin
                while (cyc < it.t + N + j) @(negedge clk);
                got[j] = prod_hi;
            end
            checks++;
            if (got !== it.p[2*N-1:N]) begin
                errors++;
                $display("FAIL R3 %s high half actual %h expected %h", it.tag, got, it.p[2*N-1:N]);
            end
            hi_done++;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            errors++;
            $display("FAIL watchdog expired actual running expected done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [N-1:0] ones;
        logic [N-1:0] x;
        ones = '1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R1: quiet after reset
        checks++;
        if (prod_lo !== 1'b0 || prod_hi !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset outputs actual %b%b expected 00", prod_lo, prod_hi);
        end

        // R3 corner: all ones, then zero, back to back (R4)
        send_word(ones, ones, 1'b0, -1, 1'b0, "R3 all-ones");
        send_word('0, ones, 1'b0, -1, 1'b0, "R4 zero after ones");
        send_word(ones, ones, 1'b0, -1, 1'b0, "R4 ones again");
        send_word(16'h0001, 16'h8000, 1'b0, -1, 1'b0, "R4 single bits");
        // R4: random back-to-back run
        for (int w = 0; w < 40; w++) begin
            send_word(N'($urandom), N'($urandom), 1'b0, -1, 1'b0, "R4 random");
        end
        // R5/R9: gap between words
        idle(N + 3);
        send_word(N'($urandom), ones, 1'b0, -1, 1'b0, "R9 from idle");
        idle(2);
        send_word(ones, N'($urandom), 1'b0, -1, 1'b0, "R5 short gap");
        idle(1);
        send_word(N'($urandom), N'($urandom), 1'b0, -1, 1'b0, "R9 one-cycle gap");
        // R6: opa noise inside the word
        for (int w = 0; w < 6; w++) begin
            send_word(N'($urandom), N'($urandom), 1'b0, -1, 1'b1, "R6 opa noise");
        end
        // R7: stray start inside a word
        send_word(N'($urandom), N'($urandom), 1'b0, 5, 1'b0, "R7 stray start");
        send_word(ones, ones, 1'b0, N - 1, 1'b1, "R7 stray at last bit");
        // R8: squaring
        x = N'($urandom);
        send_word(N'($urandom), x, 1'b0, -1, 1'b0, "R8 prime");
        send_word(N'($urandom), x, 1'b1, -1, 1'b1, "R8 square");
        send_word('0, ones, 1'b0, -1, 1'b0, "R8 prime ones");
        send_word('0, ones, 1'b1, -1, 1'b0, "R8 square ones");
        idle(4);
        send_word(N'($urandom), N'($urandom), 1'b1, -1, 1'b0, "R8 square after gap");
        idle(2 * N + 4);

        wait (lo_done == pushed && hi_done == pushed);
        if (!finished) begin
            finished = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule